// File: doc/BRIEF.md
# Trap Entry PSW Sequencer

When the processor takes one of four traps that share a single vector, this block carries out the entry sequence. It latches which cause fired and fetches the instruction at the shared vector address, which gives it the AI flag. It then saves the current program status words (PSWs) to memory, optionally saves the general registers, and reads the new PSWs. As the last new word arrives, it patches word 0 of the new PSW. The condition-code pattern and the program-counter advance that it applies are specific to the cause, so the handler can branch on the trap that brought it there.

Memory traffic uses a request/acknowledge port with one word per access. The request stays up, with address, direction and data unchanged, until the memory acknowledges it. The block does not translate addresses and does not execute the trapped instruction. A privileged-instruction trap reaches the block before the operation runs, and the PSW it saves still points at the trapped instruction. A violation trap reaches it after the instruction has been aborted, without protected memory having been written.

Top module: `trap_entry_seq`

## Requirements
- R1: A one-cycle `trap_pulse` while idle, with exactly one bit of `trap_cause` set, starts a sequence, and `busy` is high from the next cycle. The cause bits are: [0] the auxiliary cause reported with CC2, [1] privileged instruction in slave mode, [2] memory-map access violation, [3] write-lock violation. A pulse with zero bits or with several bits set is ignored: no `busy`, no memory request.
- R2: The first access of a sequence is a read of `VEC_ADDR` (hex 40). The AI flag is bit 9 of the word read, with bits numbered from the MSB, which is index `WORD_W-10`.
- R3: The old PSW words are then written, word i to `SAVE_ADDR+i` for i ascending. Word i is `cur_psw[i*WORD_W +: WORD_W]`, sampled at acceptance. For causes [2] and [3], word 3 is replaced by `fault_page`.
- R4: When `vec_is_push` was high at acceptance, register i (`gpr_file[i*WORD_W +: WORD_W]`) is written to `GPR_ADDR+i` after the PSW stores. When it was low, no register write occurs.
- R5: After all stores, the new PSW words are read from `NEW_ADDR+i` for i ascending and appear on `new_psw`, in the same word layout as `cur_psw`.
- R6: The condition code is bits `WORD_W-1` down to `WORD_W-4` of word 0, holding CC1 to CC4. The patch ORs in CC2 for cause [0], CC3 for [1], CC4 for [2], and CC3 and CC4 for [3]. All other loaded bits keep their values. `new_cc` shows the patched nibble with CC1 as the MSB.
- R7: The program counter is the low `PC_W` bits of word 0. With AI=1 it is advanced by 4, 2, 1 or 3 for causes [0], [1], [2], [3], wrapping modulo 2^`PC_W`. With AI=0 it keeps the loaded value. Words 1 and up are never altered.
- R8: `done` is a one-cycle pulse in the cycle where `busy` falls. `new_psw` and `new_cc` hold their values until the next sequence completes.
- R9: A trap pulse that arrives while `busy` is high is ignored, and the sequence in progress completes with its original cause.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable.
- R11: After reset, `busy`, `done` and `mem_req` are low and `new_psw` and `new_cc` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_pulse | input | 1 | One-cycle trap request |
| trap_cause | input | 4 | One-hot trap cause |
| vec_is_push | input | 1 | Vector holds the push-status form (store registers) |
| cur_psw | input | PSW_WORDS*WORD_W | Current PSW words, word 0 in the low bits |
| fault_page | input | WORD_W | Virtual page address of a violation |
| gpr_file | input | NGPR*WORD_W | General registers, register 0 in the low bits |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_psw | output | PSW_WORDS*WORD_W | Loaded and patched new PSWs |
| new_cc | output | 4 | Patched condition code, CC1 in bit 3 |

## Verification
The bench sweeps every cause against both AI values, both instruction forms and three program-counter values, including the two values that wrap. It also varies the memory latency. If a cause-to-pattern mapping were swapped, the handler would receive the wrong nibble or the wrong advance. An off-by-one AI bit position would advance when it should not, and a missing modulo on the addition would corrupt the bits above the PC field. The bench records the order of every access, so register stores on the exchange form, or a fault page written for the wrong causes, show up as wrong saved data. Malformed cause vectors and pulses during a sequence are also driven: a design that accepted them would start a spurious sequence or change the cause partway through.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_FETCH = 3'd1,
        PH_SAVE  = 3'd2,
        PH_GPR   = 3'd3,
        PH_LOAD  = 3'd4
    } phase_e;

    localparam int CAUSE_N     = 4;
    localparam int CC_W        = 4;
    localparam int FAULT_WORD  = 3;
    localparam int AI_FROM_MSB = 9;

    localparam int C_AUX   = 0;
    localparam int C_PRIV  = 1;
    localparam int C_ACCV  = 2;
    localparam int C_WLOCK = 3;

endpackage

// File: rtl/trap_cause_decode.sv
module trap_cause_decode
    import trap_seq_pkg::*;
(
    input  logic [CAUSE_N-1:0] cause,
    output logic               valid,
    output logic [CC_W-1:0]    cc_mask,
    output logic [2:0]         pc_off,
    output logic               page_in_save
);
    always_comb begin
        valid        = 1'b1;
        cc_mask      = '0;
        pc_off       = '0;
        page_in_save = 1'b0;
        case (cause)
            4'b0001: begin cc_mask = 4'b0100; pc_off = 3'd4; end
            4'b0010: begin cc_mask = 4'b0010; pc_off = 3'd2; end
            4'b0100: begin cc_mask = 4'b0001; pc_off = 3'd1; page_in_save = 1'b1; end
            4'b1000: begin cc_mask = 4'b0011; pc_off = 3'd3; page_in_save = 1'b1; end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/trap_psw_patch.sv
module trap_psw_patch
    import trap_seq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PC_W   = 17
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [CC_W-1:0]   cc_mask,
    input  logic [2:0]        pc_off,
    input  logic              ai,
    output logic [WORD_W-1:0] word_out
);
    localparam int CC_TOP = WORD_W - 1;

    logic [PC_W-1:0] step;
    logic [PC_W-1:0] pc_next;

    always_comb begin
        step    = ai ? PC_W'(pc_off) : '0;
        pc_next = word_in[PC_W-1:0] + step;
        word_out = word_in;
        word_out[CC_TOP -: CC_W] = word_in[CC_TOP -: CC_W] | cc_mask;
        word_out[PC_W-1:0] = pc_next;
    end

    initial begin
        assert_pc_fits_R7: assert (PC_W + CC_W <= WORD_W)
            else $error("PC field overlaps condition code");
    end
endmodule

// File: rtl/trap_store_select.sv
module trap_store_select
    import trap_seq_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int PSW_WORDS = 4,
    parameter int NGPR      = 16,
    parameter int IDX_W     = 4
) (
    input  logic                        sel_gpr,
    input  logic [IDX_W-1:0]            idx,
    input  logic [PSW_WORDS*WORD_W-1:0] old_psw,
    input  logic [WORD_W-1:0]           page,
    input  logic                        page_in_save,
    input  logic [NGPR*WORD_W-1:0]      gpr_file,
    output logic [WORD_W-1:0]           wdata
);
    localparam int PIDX_W = $clog2(PSW_WORDS);
    localparam int GIDX_W = $clog2(NGPR);

    logic [PSW_WORDS-1:0][WORD_W-1:0] save_words;
    logic [NGPR-1:0][WORD_W-1:0]      reg_words;

    assign reg_words = gpr_file;

    for (genvar i = 0; i < PSW_WORDS; i++) begin : g_save
        if (i == FAULT_WORD) begin : g_fault
            assign save_words[i] = page_in_save ? page : old_psw[i*WORD_W +: WORD_W];
        end else begin : g_plain
            assign save_words[i] = old_psw[i*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        if (sel_gpr) wdata = reg_words[idx[GIDX_W-1:0]];
        else         wdata = save_words[idx[PIDX_W-1:0]];
    end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int               WORD_W    = 32,
    parameter int               PSW_WORDS = 4,
    parameter int               NGPR      = 16,
    parameter int               PC_W      = 17,
    parameter int               ADDR_W    = 17,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = 'h40,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 'h100,
    parameter logic [ADDR_W-1:0] GPR_ADDR  = 'h120,
    parameter logic [ADDR_W-1:0] NEW_ADDR  = 'h140
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        trap_pulse,
    input  logic [CAUSE_N-1:0]          trap_cause,
    input  logic                        vec_is_push,
    input  logic [PSW_WORDS*WORD_W-1:0] cur_psw,
    input  logic [WORD_W-1:0]           fault_page,
    input  logic [NGPR*WORD_W-1:0]      gpr_file,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [WORD_W-1:0]           mem_wdata,
    input  logic [WORD_W-1:0]           mem_rdata,
    input  logic                        mem_ack,
    output logic                        busy,
    output logic                        done,
    output logic [PSW_WORDS*WORD_W-1:0] new_psw,
    output logic [CC_W-1:0]             new_cc
);
    localparam int MAXN   = (PSW_WORDS > NGPR) ? PSW_WORDS : NGPR;
    localparam int IDX_W  = $clog2(MAXN);
    localparam int PIDX_W = $clog2(PSW_WORDS);
    localparam int AI_BIT = WORD_W - 1 - AI_FROM_MSB;
    localparam logic [IDX_W-1:0] PSW_LAST = IDX_W'(PSW_WORDS - 1);
    localparam logic [IDX_W-1:0] GPR_LAST = IDX_W'(NGPR - 1);

    typedef struct packed {
        phase_e                           phase;
        logic [CAUSE_N-1:0]               cause;
        logic [IDX_W-1:0]                 idx;
        logic                             ai;
        logic                             push;
        logic [WORD_W-1:0]                page;
        logic [PSW_WORDS-1:0][WORD_W-1:0] old_psw;
        logic [PSW_WORDS-1:0][WORD_W-1:0] new_psw;
        logic                             done;
    } seq_state_t;

    seq_state_t state_q, state_d;

    logic              held_valid;
    logic [CC_W-1:0]   cc_mask;
    logic [2:0]        pc_off;
    logic              page_in_save;
    logic [WORD_W-1:0] patched_w0;
    logic [WORD_W-1:0] store_data;
    logic              accept;

    trap_cause_decode u_decode (
        .cause        (state_q.cause),
        .valid        (held_valid),
        .cc_mask      (cc_mask),
        .pc_off       (pc_off),
        .page_in_save (page_in_save)
    );

    trap_psw_patch #(.WORD_W(WORD_W), .PC_W(PC_W)) u_patch (
        .word_in  (state_q.new_psw[0]),
        .cc_mask  (cc_mask),
        .pc_off   (pc_off),
        .ai       (state_q.ai),
        .word_out (patched_w0)
    );

    trap_store_select #(
        .WORD_W(WORD_W), .PSW_WORDS(PSW_WORDS), .NGPR(NGPR), .IDX_W(IDX_W)
    ) u_select (
        .sel_gpr      (state_q.phase == PH_GPR),
        .idx          (state_q.idx),
        .old_psw      (state_q.old_psw),
        .page         (state_q.page),
        .page_in_save (page_in_save),
        .gpr_file     (gpr_file),
        .wdata        (store_data)
    );

    assign accept = trap_pulse && ($countones(trap_cause) == 1);

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        case (state_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    state_d.phase   = PH_FETCH;
                    state_d.cause   = trap_cause;
                    state_d.push    = vec_is_push;
                    state_d.page    = fault_page;
                    state_d.old_psw = cur_psw;
                    state_d.idx     = '0;
                end
            end
            PH_FETCH: begin
                if (mem_ack) begin
                    state_d.ai    = mem_rdata[AI_BIT];
                    state_d.phase = PH_SAVE;
                    state_d.idx   = '0;
                end
            end
            PH_SAVE: begin
                if (mem_ack) begin
                    if (state_q.idx == PSW_LAST) begin
                        state_d.idx   = '0;
                        state_d.phase = state_q.push ? PH_GPR : PH_LOAD;
                    end else begin
                        state_d.idx = state_q.idx + 1'b1;
                    end
                end
            end
            PH_GPR: begin
                if (mem_ack) begin
                    if (state_q.idx == GPR_LAST) begin
                        state_d.idx   = '0;
                        state_d.phase = PH_LOAD;
                    end else begin
                        state_d.idx = state_q.idx + 1'b1;
                    end
                end
            end
            PH_LOAD: begin
                if (mem_ack) begin
                    state_d.new_psw[state_q.idx[PIDX_W-1:0]] = mem_rdata;
                    if (state_q.idx == PSW_LAST) begin
                        state_d.new_psw[0] = patched_w0;
                        state_d.phase      = PH_IDLE;
                        state_d.idx        = '0;
                        state_d.done       = 1'b1;
                    end else begin
                        state_d.idx = state_q.idx + 1'b1;
                    end
                end
            end
            default: state_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        mem_req   = (state_q.phase != PH_IDLE);
        mem_we    = (state_q.phase == PH_SAVE) || (state_q.phase == PH_GPR);
        mem_wdata = store_data;
        case (state_q.phase)
            PH_SAVE: mem_addr = SAVE_ADDR + ADDR_W'(state_q.idx);
            PH_GPR:  mem_addr = GPR_ADDR + ADDR_W'(state_q.idx);
            PH_LOAD: mem_addr = NEW_ADDR + ADDR_W'(state_q.idx);
            default: mem_addr = VEC_ADDR;
        endcase
    end

    assign busy    = (state_q.phase != PH_IDLE);
    assign done    = state_q.done;
    assign new_psw = state_q.new_psw;
    assign new_cc  = state_q.new_psw[0][WORD_W-1 -: CC_W];

    // Checks next to the sequencer
    assert_cause_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> held_valid);

    assert_vector_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we && mem_addr == VEC_ADDR));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |=> $stable(new_psw));

    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trap_pulse) |=> $stable(state_q.cause));

    assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
endmodule

// File: tb/trap_entry_seq_test.sv
`timescale 1ns/1ps
module trap_entry_seq_test;
    localparam int W  = 32;
    localparam int PW = 4;
    localparam int NG = 4;
    localparam int PC = 17;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_pulse = 1'b0;
    logic [3:0] trap_cause = '0;
    logic vec_is_push = 1'b0;
    logic [PW*W-1:0] cur_psw = '0;
    logic [W-1:0] fault_page = '0;
    logic [NG*W-1:0] gpr_file = '0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [W-1:0] mem_wdata;
    logic [W-1:0] mem_rdata = '0;
    logic mem_ack = 1'b0;
    logic busy, done;
    logic [PW*W-1:0] new_psw;
    logic [3:0] new_cc;

    always #2.5 clk = ~clk;

    trap_entry_seq #(
        .WORD_W(W), .PSW_WORDS(PW), .NGPR(NG), .PC_W(PC), .ADDR_W(AW),
        .VEC_ADDR(8'h40), .SAVE_ADDR(8'h10), .GPR_ADDR(8'h20), .NEW_ADDR(8'h30)
    ) uut (
        .clk(clk), .rst_n(rst_n), .trap_pulse(trap_pulse), .trap_cause(trap_cause),
        .vec_is_push(vec_is_push), .cur_psw(cur_psw), .fault_page(fault_page),
        .gpr_file(gpr_file), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .new_psw(new_psw), .new_cc(new_cc)
    );

    int tests = 0;
    int failed = 0;

    logic [W-1:0] mem [0:255];
    logic [AW-1:0] exp_addr [0:15];
    logic exp_we [0:15];
    int seq_len = 0, acc_idx = 0, seq_err = 0, stab_err = 0, lat_mode = 0, wait_cnt = 0;
    bit pend = 0;
    logic [AW-1:0] p_addr;
    logic p_we;
    logic [W-1:0] p_wd;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // memory model, acts on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; pend = 0; wait_cnt = 0;
        end else begin
            if (pend && (!mem_req || mem_addr != p_addr || mem_we != p_we ||
                         (mem_we && mem_wdata != p_wd))) stab_err++;
            mem_ack = 1'b0;
            pend = 0;
            if (mem_req) begin
                if (wait_cnt == 0) begin
                    mem_ack = 1'b1;
                    if (acc_idx >= seq_len || mem_addr != exp_addr[acc_idx] ||
                        mem_we != exp_we[acc_idx]) seq_err++;
                    acc_idx++;
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    else        mem_rdata = mem[mem_addr];
                    wait_cnt = (acc_idx + lat_mode) % 3;
                end else begin
                    wait_cnt--;
                    pend = 1; p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
                end
            end
        end
    end

    function automatic logic [3:0] mask_of(input int c);
        case (c)
            0: return 4'b0100;
            1: return 4'b0010;
            2: return 4'b0001;
            default: return 4'b0011;
        endcase
    endfunction

    function automatic int off_of(input int c);
        case (c)
            0: return 4;
            1: return 2;
            2: return 1;
            default: return 3;
        endcase
    endfunction

    task automatic run_trap(input int run, input int c, input bit ai, input bit push,
                            input int pcsel);
        logic [3:0] cc0, ecc;
        logic [PC-1:0] pc0, epc;
        logic [W-1:0] w, ew;
        logic [PW*W-1:0] held;
        int k, cnt;
        bit bad;
        cc0 = (pcsel == 0) ? 4'h0 : (pcsel == 1) ? 4'hA : 4'h5;
        pc0 = (pcsel == 0) ? 17'h00100 : (pcsel == 1) ? 17'h1FFFF : 17'h1FFFE;
        @(negedge clk);
        k = 0;
        exp_addr[k] = 8'h40; exp_we[k] = 0; k++;
        for (int i = 0; i < PW; i++) begin exp_addr[k] = 8'h10 + 8'(i); exp_we[k] = 1; k++; end
        if (push) for (int i = 0; i < NG; i++) begin exp_addr[k] = 8'h20 + 8'(i); exp_we[k] = 1; k++; end
        for (int i = 0; i < PW; i++) begin exp_addr[k] = 8'h30 + 8'(i); exp_we[k] = 0; k++; end
        seq_len = k; acc_idx = 0; seq_err = 0; stab_err = 0; lat_mode = run % 3;
        mem[8'h40] = ai ? (32'hA5A5A5A5 | (32'h1 << 22)) : 32'hA5A5A5A5;
        for (int i = 0; i < 4; i++) begin
            mem[8'h10 + i] = 32'hDEADBEEF;
            mem[8'h20 + i] = 32'hDEADBEEF;
        end
        mem[8'h30] = {cc0, 11'h2B5, pc0};
        for (int i = 1; i < PW; i++) mem[8'h30 + i] = 32'h7700_0000 + 32'(run * 16 + i);
        for (int i = 0; i < PW; i++) cur_psw[i*W +: W] = 32'h5000_0000 + 32'(run * 256 + i);
        for (int i = 0; i < NG; i++) gpr_file[i*W +: W] = 32'hC0DE_0000 + 32'(run * 16 + i);
        fault_page = 32'h000F_A000 + 32'(run);
        vec_is_push = push;
        trap_cause = 4'(1 << c);
        trap_pulse = 1'b1;
        @(negedge clk);
        trap_pulse = 1'b0;
        vec_is_push = ~push;
        chk(busy === 1'b1, "R1", "busy after accepted pulse", 64'(busy), 64'd1);
        if (pcsel == 2) begin
            @(negedge clk);
            chk(busy === 1'b1, "R9", "busy before second pulse", 64'(busy), 64'd1);
            trap_cause = 4'(1 << ((c + 1) % 4));
            trap_pulse = 1'b1;
            @(negedge clk);
            trap_pulse = 1'b0;
        end
        cnt = 0;
        while (done !== 1'b1 && cnt < 300) begin @(negedge clk); cnt++; end
        if (done !== 1'b1) begin
            chk(1'b0, "R8", "done never arrived", 64'(done), 64'd1);
            return;
        end
        chk(busy === 1'b0, "R8", "busy low with done", 64'(busy), 64'd0);
        chk(seq_err == 0 && acc_idx == seq_len, "R2", "access order / count",
            64'(acc_idx), 64'(seq_len));
        chk(stab_err == 0, "R10", "request changed before ack", 64'(stab_err), 64'd0);
        bad = 0;
        for (int i = 0; i < PW; i++) begin
            ew = (i == 3 && c >= 2) ? fault_page : cur_psw[i*W +: W];
            if (mem[8'h10 + i] !== ew) bad = 1;
        end
        chk(!bad, "R3", "saved PSW words", 64'(mem[8'h13]), 64'((c >= 2) ? fault_page : cur_psw[3*W +: W]));
        bad = 0;
        for (int i = 0; i < NG; i++) begin
            ew = push ? gpr_file[i*W +: W] : 32'hDEADBEEF;
            if (mem[8'h20 + i] !== ew) bad = 1;
        end
        chk(!bad, "R4", "register save area", 64'(mem[8'h20]), 64'(push ? gpr_file[W-1:0] : 32'hDEADBEEF));
        ecc = cc0 | mask_of(c);
        epc = pc0 + (ai ? PC'(off_of(c)) : '0);
        w = new_psw[W-1:0];
        chk(w[31:28] === ecc, "R6", "CC in word 0", 64'(w[31:28]), 64'(ecc));
        chk(new_cc === ecc, "R6", "new_cc output", 64'(new_cc), 64'(ecc));
        chk(w[27:17] === 11'h2B5, "R6", "untouched bits of word 0", 64'(w[27:17]), 64'h2B5);
        chk(w[16:0] === epc, "R7", "program counter", 64'(w[16:0]), 64'(epc));
        bad = 0;
        for (int i = 1; i < PW; i++) if (new_psw[i*W +: W] !== mem[8'h30 + i]) bad = 1;
        chk(!bad, "R5", "loaded words 1..3", 64'(new_psw[2*W-1:W]), 64'(mem[8'h31]));
        if (pcsel == 2)
            chk(new_cc === ecc, "R9", "cause kept despite second pulse", 64'(new_cc), 64'(ecc));
        held = new_psw;
        @(negedge clk);
        chk(done === 1'b0, "R8", "done one cycle wide", 64'(done), 64'd0);
        @(negedge clk);
        chk(new_psw === held, "R8", "result held after done", 64'(new_psw[W-1:0]), 64'(held[W-1:0]));
    endtask

    task automatic bad_cause(input logic [3:0] pat);
        bit seen;
        @(negedge clk);
        trap_cause = pat;
        trap_pulse = 1'b1;
        @(negedge clk);
        trap_pulse = 1'b0;
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            if (busy !== 1'b0 || mem_req !== 1'b0 || done !== 1'b0) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R1", "malformed cause ignored", 64'(pat), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 64'd0, 64'd1);
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        int run;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R11", "control after reset",
            64'({busy, done, mem_req}), 64'd0);
        chk(new_psw === '0 && new_cc === 4'h0, "R11", "outputs after reset",
            64'(new_psw[W-1:0]), 64'd0);
        bad_cause(4'b0000);
        bad_cause(4'b0110);
        bad_cause(4'b1001);
        bad_cause(4'b1111);
        run = 0;
        for (int c = 0; c < 4; c++)
            for (int ai = 0; ai < 2; ai++)
                for (int push = 0; push < 2; push++)
                    for (int ps = 0; ps < 3; ps++) begin
                        run_trap(run, c, ai[0], push[0], ps);
                        run++;
                    end
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule